// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one cell of a programmable logic fabric. A set of product terms is formed from the cell's literal inputs (local signals plus externally supplied expander terms). Each term can use the true or the complemented form of any input. The first group of terms is ORed and then passed through an XOR stage. The second XOR input is either a constant polarity bit or a dedicated product term. The result goes through one storage element. By configuration, that element acts as a D, T, JK or SR flip-flop, as a transparent latch, or is bypassed.

Further product terms serve as controls: a clock term, a clear term, a preset term, an output-enable term and the XOR term. A configuration bit chooses how the storage element is clocked. In global mode it updates on every rising edge of the block clock. In array mode it updates on a chosen edge of the clock term, as seen at the block clock. The cell drives its feedback output and a pin data/enable pair, and the two stay independent of each other.

Top module: `mc_macrocell`

Inputs are concatenated as `{exp_in, lit_in}`, so input index k is `lit_in[k]` for k < N_LIT and `exp_in[k-N_LIT]` above that. Term t uses mask bits `[t*NIN +: NIN]`. Term numbering with GRP=3 is as follows: terms 0-2 form group A, terms 3-5 form group B, 6 is the clock, 7 is clear, 8 is preset, 9 is output enable and 10 is the XOR term.

## Requirements
- R1: A product term is the AND of every input whose true-mask bit is set and the complement of every input whose complement-mask bit is set. A term whose enable bit is 0 is 0. An enabled term with no mask bits set is 1.
- R2: The logic value x is (OR of group A terms) XOR s. s is term 10 when `cfg_xor_term`=1, and `cfg_invert` otherwise.
- R3: With `cfg_mode` 5, 6 or 7 (bypass), `fb_out` equals x in the same cycle, whatever the clock, clear and preset terms are.
- R4: With `cfg_mode`=0 (D), the state takes x at each update.
- R5: With `cfg_mode`=1 (T), the state inverts at an update when x=1 and holds when x=0.
- R6: With `cfg_mode`=2 (JK), J is x and K is the OR of the group B terms. 10 sets, 01 clears, 11 inverts and 00 holds, all at an update.
- R7: With `cfg_mode`=3 (SR), S is x and R is the OR of group B. 10 sets and 01 clears at an update. 11 and 00 hold the state.
- R8: With `cfg_mode`=4 (latch), `fb_out` follows x while the clock term is 1, and the state keeps that value while the term is 0.
- R9: An update happens at every clock edge when `cfg_arr_clk`=0. When `cfg_arr_clk`=1, it happens only at a clock edge where the clock term differs from its value at the previous edge: a 0 to 1 change, or 1 to 0 when `cfg_neg_edge`=1.
- R10: In modes 0-4, clear forces `fb_out` to 0 in the same cycle and the state to 0 at the next edge. Preset does the same to 1. Clear wins when both are active.
- R11: `pin_oe` equals the output-enable term. `pin_o` is `fb_out` while it is enabled and 0 otherwise. `fb_out` does not depend on the enable.
- R12: Reset (`rst_n`=0) clears the state and the remembered clock-term value at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lit_in | input | N_LIT | Local literal inputs |
| exp_in | input | N_EXP | Expander term inputs |
| cfg_mode | input | 3 | Storage mode: 0 D, 1 T, 2 JK, 3 SR, 4 latch, 5-7 bypass |
| cfg_arr_clk | input | 1 | 1 selects array clocking from term 6 |
| cfg_neg_edge | input | 1 | In array mode, update on the falling edge of the clock term |
| cfg_xor_term | input | 1 | Use term 10 as the second XOR input |
| cfg_invert | input | 1 | Constant second XOR input |
| cfg_term_en | input | NPT | Per-term enable |
| cfg_true_mask | input | NPT*NIN | True-literal selection per term |
| cfg_comp_mask | input | NPT*NIN | Complement-literal selection per term |
| fb_out | output | 1 | Macrocell feedback value |
| pin_o | output | 1 | Pin data |
| pin_oe | output | 1 | Pin driver enable |

## Verification
Clear and preset can be active in the same cycle, and either can coincide with an update edge. The bench raises both control terms together while the D input would load a 1. It expects 0 on `fb_out` in that cycle and after the edge. A reference model of the state tracks each vector of the table and judges every row. Directed steps cover reset, expander complement literals and the term-enable corners.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [2:0] {
        MODE_D     = 3'd0,
        MODE_T     = 3'd1,
        MODE_JK    = 3'd2,
        MODE_SR    = 3'd3,
        MODE_LATCH = 3'd4,
        MODE_COMB  = 3'd5
    } mc_mode_e;

    typedef struct packed {
        logic st;
    } store_t;

    typedef struct packed {
        logic ck_prev;
    } edge_t;

    // flip-flop next value for edge-updated modes; p = first input, q = second
    function automatic logic mc_next(input mc_mode_e m, input logic s,
                                     input logic p, input logic q);
        logic r;
        r = s;
        case (m)
            MODE_D:  r = p;
            MODE_T:  r = s ^ p;
            MODE_JK: begin
                case ({p, q})
                    2'b10:   r = 1'b1;
                    2'b01:   r = 1'b0;
                    2'b11:   r = ~s;
                    default: r = s;
                endcase
            end
            MODE_SR: begin
                case ({p, q})
                    2'b10:   r = 1'b1;
                    2'b01:   r = 1'b0;
                    default: r = s;
                endcase
            end
            default: r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mc_term_array.sv
module mc_term_array #(
    parameter int NIN = 12,
    parameter int NPT = 11
) (
    input  logic [NIN-1:0]     in_i,
    input  logic [NPT*NIN-1:0] tmask_i,
    input  logic [NPT*NIN-1:0] cmask_i,
    input  logic [NPT-1:0]     en_i,
    output logic [NPT-1:0]     term_o
);

    for (genvar k = 0; k < NPT; k++) begin : g_term
        logic [NIN-1:0] hit_w;
        assign hit_w     = (~tmask_i[k*NIN +: NIN] | in_i) &
                           (~cmask_i[k*NIN +: NIN] | ~in_i);
        assign term_o[k] = en_i[k] & (&hit_w);
    end

endmodule

// File: rtl/mc_clock_sel.sv
module mc_clock_sel
    import mc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arr_i,
    input  logic neg_i,
    input  logic ck_term_i,
    output logic upd_o
);

    edge_t cur_q, nxt_d;

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.ck_prev = ck_term_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        if (!arr_i)     upd_o = 1'b1;
        else if (neg_i) upd_o = cur_q.ck_prev & ~ck_term_i;
        else            upd_o = ~cur_q.ck_prev & ck_term_i;
    end

    // same-direction edges of the clock term cannot occur on two edges in a row
    assert_arr_edge_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_i && upd_o) |=> (!upd_o || !arr_i || (neg_i != $past(neg_i))));

endmodule

// File: rtl/mc_storage.sv
module mc_storage
    import mc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  mc_mode_e mode_i,
    input  logic     upd_i,
    input  logic     ck_i,
    input  logic     clr_i,
    input  logic     pre_i,
    input  logic     x_i,
    input  logic     b_i,
    output logic     st_o
);

    store_t cur_q, nxt_d;
    logic   edge_mode_w;

    assign edge_mode_w = (mode_i == MODE_D) || (mode_i == MODE_T) ||
                         (mode_i == MODE_JK) || (mode_i == MODE_SR);

    always_comb begin
        nxt_d = cur_q;
        if (clr_i) begin
            nxt_d.st = 1'b0;
        end else if (pre_i) begin
            nxt_d.st = 1'b1;
        end else if (mode_i == MODE_LATCH) begin
            if (ck_i) nxt_d.st = x_i;
        end else if (edge_mode_w && upd_i) begin
            nxt_d.st = mc_next(mode_i, cur_q.st, x_i, b_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign st_o = cur_q.st;

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !st_o);

    assert_preset_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_i && !clr_i) |=> st_o);

    assert_d_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_D && upd_i && !clr_i && !pre_i) |=> (st_o == $past(x_i)));

    assert_jk_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_JK && upd_i && x_i && b_i && !clr_i && !pre_i)
        |=> (st_o != $past(st_o)));

    assert_sr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SR && x_i && b_i && !clr_i && !pre_i) |=> $stable(st_o));

    assert_no_update_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_w && !upd_i && !clr_i && !pre_i) |=> $stable(st_o));

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
    import mc_pkg::*;
#(
    parameter  int N_LIT = 8,
    parameter  int N_EXP = 4,
    parameter  int GRP   = 3,
    localparam int NIN   = N_LIT + N_EXP,
    localparam int NPT   = 2 * GRP + 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LIT-1:0]   lit_in,
    input  logic [N_EXP-1:0]   exp_in,
    input  logic [2:0]         cfg_mode,
    input  logic               cfg_arr_clk,
    input  logic               cfg_neg_edge,
    input  logic               cfg_xor_term,
    input  logic               cfg_invert,
    input  logic [NPT-1:0]     cfg_term_en,
    input  logic [NPT*NIN-1:0] cfg_true_mask,
    input  logic [NPT*NIN-1:0] cfg_comp_mask,
    output logic               fb_out,
    output logic               pin_o,
    output logic               pin_oe
);

    localparam int T_CK  = 2 * GRP;
    localparam int T_CLR = T_CK + 1;
    localparam int T_PRE = T_CK + 2;
    localparam int T_OE  = T_CK + 3;
    localparam int T_XT  = T_CK + 4;

    logic [NIN-1:0] in_w;
    logic [NPT-1:0] term_w;
    logic           sum_a_w, sum_b_w, xsec_w, x_w, upd_w, st_w;
    mc_mode_e       mode_w;

    assign in_w   = {exp_in, lit_in};
    assign mode_w = mc_mode_e'(cfg_mode);

    mc_term_array #(.NIN(NIN), .NPT(NPT)) u_terms (
        .in_i    (in_w),
        .tmask_i (cfg_true_mask),
        .cmask_i (cfg_comp_mask),
        .en_i    (cfg_term_en),
        .term_o  (term_w)
    );

    assign sum_a_w = |term_w[GRP-1:0];
    assign sum_b_w = |term_w[2*GRP-1:GRP];
    assign xsec_w  = cfg_xor_term ? term_w[T_XT] : cfg_invert;
    assign x_w     = sum_a_w ^ xsec_w;

    mc_clock_sel u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .arr_i     (cfg_arr_clk),
        .neg_i     (cfg_neg_edge),
        .ck_term_i (term_w[T_CK]),
        .upd_o     (upd_w)
    );

    mc_storage u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_w),
        .upd_i  (upd_w),
        .ck_i   (term_w[T_CK]),
        .clr_i  (term_w[T_CLR]),
        .pre_i  (term_w[T_PRE]),
        .x_i    (x_w),
        .b_i    (sum_b_w),
        .st_o   (st_w)
    );

    always_comb begin
        case (mode_w)
            MODE_D, MODE_T, MODE_JK, MODE_SR, MODE_LATCH: begin
                if (term_w[T_CLR])                           fb_out = 1'b0;
                else if (term_w[T_PRE])                      fb_out = 1'b1;
                else if (mode_w == MODE_LATCH && term_w[T_CK]) fb_out = x_w;
                else                                         fb_out = st_w;
            end
            default: fb_out = x_w;
        endcase
    end

    assign pin_oe = term_w[T_OE];
    assign pin_o  = term_w[T_OE] & fb_out;

    assert_clear_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (term_w[T_CLR] && cfg_mode < 3'd5) |-> !fb_out);

    assert_pin_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_o);

endmodule

// File: tb/mc_macrocell_tb.sv
module mc_macrocell_tb;

    localparam int NIN = 12;
    localparam int NPT = 11;
    localparam int NV  = 24;

    // row: {mode[2:0], arr, neg, xsel, inv, inputs[11:0]}
    localparam logic [18:0] VEC [NV] = '{
        {3'd0, 4'b0000, 12'h201},  // R4 load 1, R11 pin enabled
        {3'd0, 4'b0000, 12'h000},  // R4 load 0
        {3'd0, 4'b0001, 12'h000},  // R2 constant invert
        {3'd0, 4'b0010, 12'h401},  // R2 xor term cancels
        {3'd1, 4'b0000, 12'h201},  // R5 toggle
        {3'd1, 4'b0000, 12'h001},  // R5 toggle
        {3'd1, 4'b0000, 12'h000},  // R5 hold
        {3'd2, 4'b0000, 12'h001},  // R6 set
        {3'd2, 4'b0000, 12'h008},  // R6 clear
        {3'd2, 4'b0000, 12'h009},  // R6 toggle
        {3'd2, 4'b0000, 12'h009},  // R6 toggle
        {3'd3, 4'b0000, 12'h002},  // R7 set
        {3'd3, 4'b0000, 12'h012},  // R7 both: hold
        {3'd3, 4'b0000, 12'h010},  // R7 reset
        {3'd0, 4'b1000, 12'h001},  // R9 no clock-term edge
        {3'd0, 4'b1000, 12'h041},  // R9 rising edge captures
        {3'd0, 4'b1000, 12'h040},  // R9 term stays high: hold
        {3'd0, 4'b1100, 12'h000},  // R9 falling edge captures
        {3'd4, 4'b0000, 12'h041},  // R8 transparent
        {3'd4, 4'b0000, 12'h000},  // R8 hold
        {3'd4, 4'b0000, 12'h040},  // R8 transparent low
        {3'd5, 4'b0000, 12'h181},  // R3 bypass ignores clear/preset
        {3'd0, 4'b0000, 12'h181},  // R10 clear and preset together
        {3'd0, 4'b0000, 12'h101}   // R10 preset
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic [7:0]         lit_in;
    logic [3:0]         exp_in;
    logic [2:0]         cfg_mode;
    logic               cfg_arr_clk, cfg_neg_edge, cfg_xor_term, cfg_invert;
    logic [NPT-1:0]     cfg_term_en;
    logic [NPT*NIN-1:0] cfg_true_mask, cfg_comp_mask;
    logic               fb_out, pin_o, pin_oe;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    logic m_st, m_prev;

    always #5 clk = ~clk;

    mc_macrocell u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .lit_in        (lit_in),
        .exp_in        (exp_in),
        .cfg_mode      (cfg_mode),
        .cfg_arr_clk   (cfg_arr_clk),
        .cfg_neg_edge  (cfg_neg_edge),
        .cfg_xor_term  (cfg_xor_term),
        .cfg_invert    (cfg_invert),
        .cfg_term_en   (cfg_term_en),
        .cfg_true_mask (cfg_true_mask),
        .cfg_comp_mask (cfg_comp_mask),
        .fb_out        (fb_out),
        .pin_o         (pin_o),
        .pin_oe        (pin_oe)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic identity_cfg();
        cfg_true_mask = '0;
        cfg_comp_mask = '0;
        for (int k = 0; k < NPT; k++) cfg_true_mask[k*NIN + k] = 1'b1;
        cfg_term_en = '1;
    endtask

    task automatic drive(input logic [11:0] v);
        lit_in = v[7:0];
        exp_in = v[11:8];
    endtask

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0:    return "R4";
            3'd1:    return "R5";
            3'd2:    return "R6";
            3'd3:    return "R7";
            3'd4:    return "R8";
            default: return "R3";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired (R1..R12 incomplete)");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        identity_cfg();
        cfg_mode = 3'd0; cfg_arr_clk = 1'b0; cfg_neg_edge = 1'b0;
        cfg_xor_term = 1'b0; cfg_invert = 1'b0;
        drive(12'h000);
        repeat (3) @(negedge clk);
        chk("R12 reset fb", fb_out, 1'b0);
        chk("R12 reset pin_oe", pin_oe, 1'b0);
        rst_n = 1'b1;
        m_st = 1'b0; m_prev = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            logic [2:0]  md;
            logic        ar, ng, xs, iv, ck, cl, pr, oe, xv, bv, upd, exp_fb, nx;
            @(negedge clk);
            md = VEC[i][18:16]; ar = VEC[i][15]; ng = VEC[i][14];
            xs = VEC[i][13];    iv = VEC[i][12]; v = VEC[i][11:0];
            cfg_mode = md; cfg_arr_clk = ar; cfg_neg_edge = ng;
            cfg_xor_term = xs; cfg_invert = iv;
            drive(v);
            #1;
            ck = v[6]; cl = v[7]; pr = v[8]; oe = v[9];
            xv = (|v[2:0]) ^ (xs ? v[10] : iv);
            bv = |v[5:3];
            if (md >= 3'd5)            exp_fb = xv;
            else if (cl)               exp_fb = 1'b0;
            else if (pr)               exp_fb = 1'b1;
            else if (md == 3'd4 && ck) exp_fb = xv;
            else                       exp_fb = m_st;
            chk({req_of(md), " R2 R10 fb row"}, fb_out, exp_fb);
            chk("R11 pin_oe row", pin_oe, oe);
            chk("R11 pin_o row", pin_o, oe & exp_fb);
            upd = !ar ? 1'b1 : (ng ? (m_prev & ~ck) : (~m_prev & ck));
            nx = m_st;
            if (cl)                nx = 1'b0;
            else if (pr)           nx = 1'b1;
            else if (md == 3'd4)   nx = ck ? xv : m_st;
            else if (md < 3'd4 && upd) begin
                case (md)
                    3'd0: nx = xv;
                    3'd1: nx = m_st ^ xv;
                    3'd2: nx = ({xv, bv} == 2'b10) ? 1'b1 : ({xv, bv} == 2'b01) ? 1'b0 :
                               ({xv, bv} == 2'b11) ? ~m_st : m_st;
                    default: nx = ({xv, bv} == 2'b10) ? 1'b1 :
                                  ({xv, bv} == 2'b01) ? 1'b0 : m_st;
                endcase
            end
            @(posedge clk);
            m_st = nx; m_prev = ck;
        end

        // R10: state after clear+preset row was 0, preset row set it to 1
        @(negedge clk);
        cfg_mode = 3'd0; cfg_arr_clk = 1'b0; cfg_xor_term = 1'b0; cfg_invert = 1'b0;
        drive(12'h000);
        #1 chk("R10 preset held in state", fb_out, 1'b1);

        // R12: mid-run reset clears state at once
        rst_n = 1'b0;
        #1 chk("R12 async reset clears fb", fb_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: term from complement of an expander input
        cfg_mode = 3'd5;
        cfg_true_mask[0 +: NIN] = '0;
        cfg_comp_mask[0 +: NIN] = 12'h800;
        drive(12'h000);
        #1 chk("R1 complement literal true", fb_out, 1'b1);
        drive(12'h800);
        #1 chk("R1 complement literal false", fb_out, 1'b0);
        cfg_comp_mask[0 +: NIN] = '0;
        #1 chk("R1 empty enabled term is 1", fb_out, 1'b1);
        cfg_term_en[0] = 1'b0;
        #1 chk("R1 disabled term is 0", fb_out, 1'b0);
        identity_cfg();

        // R11: feedback independent of pin enable
        drive(12'h001);
        #1 chk("R11 fb with pin disabled", fb_out, 1'b1);
        chk("R11 pin_o off", pin_o, 1'b0);
        drive(12'h201);
        #1 chk("R11 pin_o driven", pin_o, 1'b1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule